// File: doc/BRIEF.md
# ADC-to-DAC Loopback Router

This block decides where the DAC playback path takes its samples from. In normal operation the DAC reads one of two external serial-input channels. A one-bit channel select chooses between them. In loopback operation the DAC reads the parallel sample stream coming out of the ADC capture path instead. The ADC sample stream always continues to the serial output, together with the ADC format bit, whatever the loopback state.

The DAC interface format is a 2-bit field, held as two registers. Every write lands in a shadow copy. The active copy, which drives the format-select output, follows writes directly only while loopback is off. While loopback is on, writes are held back. The most recent value is applied at the moment loopback is released.

Requests to change the loopback state or the channel select take effect only on a sample-frame strobe, so a sample is never split between two sources. Every such change forces the DAC data to zero for a parameterised number of whole frames. The data is released again on a frame strobe.

Top module: `loopback_router`

## Requirements
- R1: After reset, loop_active and src_active are 0, dac_fmt is 2'b00, dac_zero is 0, and dac_data follows ext_a_data.
- R2: loop_req and src_req are copied into loop_active and src_active only on a rising clock edge where frame_tick is 1. On all other edges loop_active and src_active hold their value.
- R3: While loop_active is 1 and dac_zero is 0, dac_data equals adc_data.
- R4: While loop_active is 0 and dac_zero is 0, dac_data equals ext_a_data when src_active is 0 and ext_b_data when src_active is 1.
- R5: While loop_active is 0, a write (fmt_we = 1 with value fmt_wdata) sets dac_fmt to fmt_wdata from the next cycle onward.
- R6: While loop_active is 1, writes to the format field leave dac_fmt unchanged.
- R7: On the frame edge that clears loop_active, dac_fmt takes the most recently written format value. A write in that same cycle counts as the most recent one.
- R8: sdout_data always equals adc_data, and sdout_fmt always equals adc_fmt, independent of the loopback state.
- R9: A frame edge that changes loop_active or src_active sets dac_zero to 1 and forces dac_data to 0. Both stay that way until the MUTE_FRAMES-th later frame edge (default 2), which clears dac_zero.
- R10: A frame edge that changes neither loop_active nor src_active does not start a zero period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_tick | input | 1 | One-cycle sample-frame boundary strobe |
| loop_req | input | 1 | Requested loopback state |
| src_req | input | 1 | Requested external channel (0 = A, 1 = B) |
| fmt_we | input | 1 | DAC format write enable |
| fmt_wdata | input | 2 | DAC format write value |
| adc_fmt | input | 1 | ADC serial output format bit |
| adc_data | input | DW | ADC parallel sample |
| ext_a_data | input | DW | External channel A sample |
| ext_b_data | input | DW | External channel B sample |
| dac_data | output | DW | Sample delivered to the DAC |
| dac_fmt | output | 2 | Active DAC format select |
| dac_zero | output | 1 | DAC forced to zero data |
| sdout_data | output | DW | Sample for the serial output encoder |
| sdout_fmt | output | 1 | Format select for the serial output encoder |
| loop_active | output | 1 | Applied loopback state |
| src_active | output | 1 | Applied external channel |

## Verification
The hardest case to reach is a format write that coincides with the frame edge that releases loopback. Several writes are also made while loopback is held. The stimulus enters loopback and makes two writes, checking after each that the active format has not moved. It then clears the loop request and asserts a write on the same strobe cycle. This shows that the released format is the newest value and not a stale shadow copy. The zero-data window is checked cycle by cycle. Strobes are spaced so that non-strobe cycles inside the window are observed as well.

// File: rtl/loopback_router.sv
module loopback_router #(
  parameter int DW          = 24,
  parameter int MUTE_FRAMES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          loop_req,
  input  logic          src_req,
  input  logic          fmt_we,
  input  logic [1:0]    fmt_wdata,
  input  logic          adc_fmt,
  input  logic [DW-1:0] adc_data,
  input  logic [DW-1:0] ext_a_data,
  input  logic [DW-1:0] ext_b_data,
  output logic [DW-1:0] dac_data,
  output logic [1:0]    dac_fmt,
  output logic          dac_zero,
  output logic [DW-1:0] sdout_data,
  output logic          sdout_fmt,
  output logic          loop_active,
  output logic          src_active
);
  localparam int CW = $clog2(MUTE_FRAMES + 1);

  logic          loop_q, sel_q;
  logic [1:0]    fmt_shadow, fmt_live;
  logic [CW-1:0] mute_cnt;
  logic          switching, loop_clearing;
  logic [1:0]    newest_fmt;
  logic [DW-1:0] routed;

  assign switching     = frame_tick && ((loop_req != loop_q) || (src_req != sel_q));
  assign loop_clearing = frame_tick && loop_q && !loop_req;
  assign newest_fmt    = fmt_we ? fmt_wdata : fmt_shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loop_q <= 1'b0;
      sel_q  <= 1'b0;
    end else if (frame_tick) begin
      loop_q <= loop_req;
      sel_q  <= src_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_shadow <= 2'b00;
      fmt_live   <= 2'b00;
    end else begin
      if (fmt_we)
        fmt_shadow <= fmt_wdata;
      if (loop_clearing)
        fmt_live <= newest_fmt;
      else if (!loop_q && fmt_we)
        fmt_live <= fmt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mute_cnt <= '0;
    else if (switching)
      mute_cnt <= CW'(MUTE_FRAMES);
    else if (frame_tick && mute_cnt != '0)
      mute_cnt <= mute_cnt - 1'b1;
  end

  assign routed      = loop_q ? adc_data : (sel_q ? ext_b_data : ext_a_data);
  assign dac_zero    = (mute_cnt != '0);
  assign dac_data    = dac_zero ? '0 : routed;
  assign dac_fmt     = fmt_live;
  assign sdout_data  = adc_data;
  assign sdout_fmt   = adc_fmt;
  assign loop_active = loop_q;
  assign src_active  = sel_q;
endmodule

module loopback_router_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_tick,
  input logic          loop_req,
  input logic          src_req,
  input logic          fmt_we,
  input logic [1:0]    fmt_wdata,
  input logic [DW-1:0] dac_data,
  input logic [1:0]    dac_fmt,
  input logic          dac_zero,
  input logic          loop_active,
  input logic          src_active
);
  // R2
  hold_off_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ($stable(loop_active) && $stable(src_active)));

  // R5
  fmt_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_active && fmt_we && !frame_tick) |=> (dac_fmt == $past(fmt_wdata)));

  // R6
  fmt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && !frame_tick) |=> $stable(dac_fmt));

  // R9
  zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_zero |-> (dac_data == '0));

  // R9
  mute_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && ((loop_req != loop_active) || (src_req != src_active))) |=> dac_zero);

  // R10
  no_spurious_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_zero && frame_tick && loop_req == loop_active && src_req == src_active) |=> !dac_zero);
endmodule

bind loopback_router loopback_router_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .loop_req(loop_req),
  .src_req(src_req), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata), .dac_data(dac_data),
  .dac_fmt(dac_fmt), .dac_zero(dac_zero), .loop_active(loop_active),
  .src_active(src_active)
);

// File: tb/loopback_router_tb.sv
module loopback_router_tb;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_tick = 1'b0;
  logic          loop_req = 1'b0;
  logic          src_req = 1'b0;
  logic          fmt_we = 1'b0;
  logic [1:0]    fmt_wdata = 2'b00;
  logic          adc_fmt = 1'b0;
  logic [DW-1:0] adc_data = 24'h0ABCDE;
  logic [DW-1:0] ext_a_data = 24'h111111;
  logic [DW-1:0] ext_b_data = 24'h222222;
  logic [DW-1:0] dac_data, sdout_data;
  logic [1:0]    dac_fmt;
  logic          dac_zero, sdout_fmt, loop_active, src_active;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  loopback_router #(.DW(DW), .MUTE_FRAMES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .loop_req(loop_req),
    .src_req(src_req), .fmt_we(fmt_we), .fmt_wdata(fmt_wdata), .adc_fmt(adc_fmt),
    .adc_data(adc_data), .ext_a_data(ext_a_data), .ext_b_data(ext_b_data),
    .dac_data(dac_data), .dac_fmt(dac_fmt), .dac_zero(dac_zero),
    .sdout_data(sdout_data), .sdout_fmt(sdout_fmt), .loop_active(loop_active),
    .src_active(src_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic ft);
    @(negedge clk);
    frame_tick = ft;
    @(posedge clk);
    #1;
    frame_tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 loop_active", 32'(loop_active), 0);
    check("R1 src_active", 32'(src_active), 0);
    check("R1 dac_fmt", 32'(dac_fmt), 0);
    check("R1 dac_zero", 32'(dac_zero), 0);
    check("R1 dac_data", 32'(dac_data), 32'h111111);
  endtask

  task automatic t_select_ext;
    src_req = 1'b1;
    step(1'b0);
    check("R2 no strobe", 32'(src_active), 0);
    step(1'b1);
    check("R2 strobe", 32'(src_active), 1);
    check("R9 zero flag", 32'(dac_zero), 1);
    check("R9 zero data", 32'(dac_data), 0);
    step(1'b0);
    check("R9 between strobes", 32'(dac_zero), 1);
    step(1'b1);
    check("R9 one frame", 32'(dac_zero), 1);
    step(1'b1);
    check("R9 release", 32'(dac_zero), 0);
    check("R4 channel B", 32'(dac_data), 32'h222222);
    src_req = 1'b0;
    step(1'b1); step(1'b1); step(1'b1);
    check("R4 channel A", 32'(dac_data), 32'h111111);
  endtask

  task automatic t_no_mute;
    step(1'b1);
    check("R10 no change", 32'(dac_zero), 0);
    check("R10 data live", 32'(dac_data), 32'h111111);
  endtask

  task automatic t_fmt_direct;
    fmt_we = 1'b1; fmt_wdata = 2'b10;
    step(1'b0);
    fmt_we = 1'b0;
    check("R5 direct write", 32'(dac_fmt), 2);
  endtask

  task automatic t_loop;
    loop_req = 1'b1;
    step(1'b1);
    check("R2 loop applied", 32'(loop_active), 1);
    fmt_we = 1'b1; fmt_wdata = 2'b01;
    step(1'b0);
    check("R6 first write held", 32'(dac_fmt), 2);
    fmt_wdata = 2'b11;
    step(1'b0);
    fmt_we = 1'b0;
    check("R6 second write held", 32'(dac_fmt), 2);
    step(1'b1); step(1'b1);
    check("R3 adc routed", 32'(dac_data), 32'h0ABCDE);
    adc_fmt = 1'b1;
    adc_data = 24'h5A5A5A;
    #1;
    check("R3 adc follows", 32'(dac_data), 32'h5A5A5A);
    check("R8 sdout data", 32'(sdout_data), 32'h5A5A5A);
    check("R8 sdout fmt", 32'(sdout_fmt), 1);
    loop_req = 1'b0;
    step(1'b1);
    check("R7 latest applied", 32'(dac_fmt), 3);
    check("R9 zero on exit", 32'(dac_zero), 1);
    check("R8 sdout out of loop", 32'(sdout_data), 32'h5A5A5A);
  endtask

  task automatic t_loop_same_cycle;
    loop_req = 1'b1;
    step(1'b1); step(1'b1); step(1'b1);
    loop_req = 1'b0; fmt_we = 1'b1; fmt_wdata = 2'b00;
    step(1'b1);
    fmt_we = 1'b0;
    check("R7 same-cycle write", 32'(dac_fmt), 0);
    check("R2 loop cleared", 32'(loop_active), 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_select_ext();
    t_no_mute();
    t_fmt_direct();
    t_loop();
    t_loop_same_cycle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule